// File: doc/BRIEF.md
# Core Special I/O Register Bank

This block sits between the core's byte-wide I/O port path and the rest of the machine. The port space has 64 addresses. The eight highest ports are served from registers kept inside the block: four data-space extension bytes, one indirect-jump extension byte, the two halves of the stack pointer and the status register. Every lower port is passed to an external peripheral bus, which is offset by a configurable base address.

Each extension byte is held shifted into bits 23:16 of a 24-bit value, so the core can join it directly onto a 16-bit pointer. Each of the four data-space extensions can be left out by configuration, and the stack pointer can be built 8 or 16 bits wide. A read of an internal port completes in the same cycle. A read of an external port completes once the bus reports ready.

Top module: `core_io_regfile`

## Requirements
- R1: After reset, the four data-space extension values, the jump extension value, the stack pointer and the status register all read zero, both at the ports and on the exposed outputs.
- R2: A write to port 0x38+k (k = 0..3) with bit k of `XD_EN` set stores the byte in bits 23:16 of data-space extension k, with bits 15:0 zero. Extension k appears on `dext_o[24*k +: 24]`, and a read of its port returns bits 23:16.
- R3: A write to port 0x38+k whose bit k of `XD_EN` is clear leaves that extension unchanged, so it still reads zero.
- R4: A write to port 0x3C always stores the byte in bits 23:16 of the jump extension on `jext_o`, and a read of port 0x3C returns that byte.
- R5: Port 0x3D reads the low stack-pointer byte. A write to it replaces `sp_o[7:0]` only.
- R6: Port 0x3E reads `sp_o[15:8]`. A write to it replaces those bits when `SP_WIDE` = 1 and is ignored when `SP_WIDE` = 0.
- R7: Port 0x3F reads and writes the status register, which is exposed on `sreg_o`.
- R8: Only bits 7:0 of `io_wdata` are used. Upper bits affect neither stored values nor `ext_wdata`.
- R9: For a port in 0x00..0x37, a read or a write raises `ext_req`, and `ext_addr` = `IO_BASE` + port. `ext_we` follows `io_wr`, and `ext_wdata` carries the byte. A port in 0x38..0x3F never raises `ext_req`, and an external write changes no internal register.
- R10: A read of an internal port gives `io_ready` = 1 and valid `io_rdata` in the same cycle. A read of an external port gives `io_ready` = `ext_ready` and `io_rdata` = `ext_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_addr | input | PORT_W | I/O port number |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | WIN_W | Write data; only bits 7:0 are used |
| io_rdata | output | 8 | Read data |
| io_ready | output | 1 | Read data valid / access complete |
| ext_req | output | 1 | External bus request |
| ext_we | output | 1 | External bus write enable |
| ext_addr | output | EA_W | External bus address |
| ext_wdata | output | 8 | External bus write byte |
| ext_rdata | input | 8 | External bus read byte |
| ext_ready | input | 1 | External bus ready |
| dext_o | output | 96 | Data-space extensions 0..3, 24 bits each |
| jext_o | output | 24 | Indirect-jump extension |
| sp_o | output | 16 | Stack pointer |
| sreg_o | output | 8 | Status register |

## Verification
The bench builds two instances that share their inputs. One has every data-space extension present and a 16-bit stack pointer. The other has `XD_EN` = 4'b0101 and `SP_WIDE` = 0, which makes the gated writes to extensions 1 and 3 and to the high stack-pointer byte observable beside their accepted counterparts. With these two builds, a sweep over all 64 ports reaches every decode path in both settings. The sweep uses write data with the upper bits set, so the byte mask is checked on every access.

// File: rtl/core_io_pkg.sv
package core_io_pkg;

  localparam int XW = 24;   // width of an extension value
  localparam int SPW = 16;  // stack pointer width

  // Port offset within the internal window; order follows the port numbers.
  typedef enum logic [2:0] {
    SL_XD0  = 3'd0,
    SL_XD1  = 3'd1,
    SL_XD2  = 3'd2,
    SL_XD3  = 3'd3,
    SL_JMP  = 3'd4,
    SL_SPL  = 3'd5,
    SL_SPH  = 3'd6,
    SL_STAT = 3'd7
  } slot_e;

  // Place a byte at the top of an extension value.
  function automatic logic [XW-1:0] ext_place(input logic [7:0] b);
    return {b, {(XW-8){1'b0}}};
  endfunction

  // Recover the byte from an extension value.
  function automatic logic [7:0] ext_byte(input logic [XW-1:0] v);
    return v[XW-1 -: 8];
  endfunction

  function automatic logic [SPW-1:0] sp_set_lo(input logic [SPW-1:0] sp,
                                               input logic [7:0] b);
    return {sp[SPW-1:8], b};
  endfunction

  function automatic logic [SPW-1:0] sp_set_hi(input logic [SPW-1:0] sp,
                                               input logic [7:0] b);
    return {b, sp[7:0]};
  endfunction

endpackage

// File: rtl/cio_decode.sv
module cio_decode
  import core_io_pkg::*;
#(
  parameter int PORT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic              core_hit,
  output slot_e             slot,
  output logic [7:0]        core_wr,
  output logic              ext_req
);

  always_comb begin
    core_hit = &io_addr[PORT_W-1:3];
    slot     = slot_e'(io_addr[2:0]);
    core_wr  = (io_wr && core_hit) ? (8'd1 << io_addr[2:0]) : 8'd0;
    ext_req  = (io_rd || io_wr) && !core_hit;
  end

  p_one_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_wr) && !(ext_req && (core_wr != 8'd0)));

  p_no_ext_for_core_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr[PORT_W-1:3] == {(PORT_W-3){1'b1}}) |-> !ext_req);

endmodule

// File: rtl/cio_ext_bank.sv
module cio_ext_bank
  import core_io_pkg::*;
#(
  parameter int         NXD   = 4,
  parameter logic [3:0] XD_EN = 4'hF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NXD:0]       wr_stb,
  input  logic [7:0]         wbyte,
  output logic [(NXD+1)*XW-1:0] vals
);

  localparam int NREG = NXD + 1;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam bit PRESENT = (g == NXD) ? 1'b1 : XD_EN[g];
    logic [XW-1:0] r;
    wire           take = wr_stb[g] && PRESENT;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    r <= '0;
      else if (take) r <= ext_place(wbyte);
    end

    assign vals[g*XW +: XW] = r;

    if (PRESENT) begin : g_on
      p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb[g] |=> (ext_byte(r) == $past(wbyte)) && (r[XW-9:0] == '0));
    end else begin : g_off
      p_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb[g] |=> $stable(r));
    end
  end

endmodule

// File: rtl/cio_sp_stat.sv
module cio_sp_stat
  import core_io_pkg::*;
#(
  parameter bit SP_WIDE = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_lo,
  input  logic           wr_hi,
  input  logic           wr_st,
  input  logic [7:0]     wbyte,
  output logic [SPW-1:0] sp,
  output logic [7:0]     sreg
);

  wire hi_take = wr_hi && SP_WIDE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp   <= '0;
      sreg <= '0;
    end else begin
      if (wr_lo)   sp <= sp_set_lo(sp, wbyte);
      if (hi_take) sp <= sp_set_hi(sp, wbyte);
      if (wr_st)   sreg <= wbyte;
    end
  end

  p_lo_keeps_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (sp[7:0] == $past(wbyte)) && (sp[15:8] == $past(sp[15:8])));

  p_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_st |=> sreg == $past(wbyte));

  if (SP_WIDE) begin : g_wide
    p_hi_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> sp[15:8] == $past(wbyte));
  end else begin : g_narrow
    p_hi_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> $stable(sp));
  end

endmodule

// File: rtl/cio_rd_mux.sv
module cio_rd_mux
  import core_io_pkg::*;
#(
  parameter int NXD = 4
) (
  input  logic                  core_hit,
  input  slot_e                 slot,
  input  logic [(NXD+1)*XW-1:0] vals,
  input  logic [SPW-1:0]        sp,
  input  logic [7:0]            sreg,
  input  logic [7:0]            ext_rdata,
  input  logic                  ext_ready,
  output logic [7:0]            rdata,
  output logic                  ready
);

  logic [7:0] core_byte;

  always_comb begin
    unique case (slot)
      SL_XD0:  core_byte = ext_byte(vals[0*XW +: XW]);
      SL_XD1:  core_byte = ext_byte(vals[1*XW +: XW]);
      SL_XD2:  core_byte = ext_byte(vals[2*XW +: XW]);
      SL_XD3:  core_byte = ext_byte(vals[3*XW +: XW]);
      SL_JMP:  core_byte = ext_byte(vals[NXD*XW +: XW]);
      SL_SPL:  core_byte = sp[7:0];
      SL_SPH:  core_byte = sp[15:8];
      default: core_byte = sreg;
    endcase
    rdata = core_hit ? core_byte : ext_rdata;
    ready = core_hit ? 1'b1 : ext_ready;
  end

endmodule

// File: rtl/core_io_regfile.sv
module core_io_regfile
  import core_io_pkg::*;
#(
  parameter int          PORT_W  = 6,
  parameter int          WIN_W   = 16,
  parameter int          EA_W    = 16,
  parameter logic [15:0] IO_BASE = 16'h0020,
  parameter logic [3:0]  XD_EN   = 4'hF,
  parameter bit          SP_WIDE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [WIN_W-1:0]  io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_ready,
  output logic              ext_req,
  output logic              ext_we,
  output logic [EA_W-1:0]   ext_addr,
  output logic [7:0]        ext_wdata,
  input  logic [7:0]        ext_rdata,
  input  logic              ext_ready,
  output logic [95:0]       dext_o,
  output logic [23:0]       jext_o,
  output logic [15:0]       sp_o,
  output logic [7:0]        sreg_o
);

  localparam int NXD = 4;

  logic                 core_hit;
  slot_e                slot;
  logic [7:0]           core_wr;
  logic [7:0]           wbyte;
  logic [(NXD+1)*XW-1:0] vals;
  wire                  wdata_hi_seen = |io_wdata[WIN_W-1:8];

  assign wbyte = io_wdata[7:0];

  cio_decode #(.PORT_W(PORT_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .core_hit(core_hit), .slot(slot), .core_wr(core_wr), .ext_req(ext_req)
  );

  cio_ext_bank #(.NXD(NXD), .XD_EN(XD_EN)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_stb(core_wr[NXD:0]), .wbyte(wbyte), .vals(vals)
  );

  cio_sp_stat #(.SP_WIDE(SP_WIDE)) u_spst (
    .clk(clk), .rst_n(rst_n),
    .wr_lo(core_wr[SL_SPL]), .wr_hi(core_wr[SL_SPH]), .wr_st(core_wr[SL_STAT]),
    .wbyte(wbyte), .sp(sp_o), .sreg(sreg_o)
  );

  cio_rd_mux #(.NXD(NXD)) u_mux (
    .core_hit(core_hit), .slot(slot), .vals(vals), .sp(sp_o), .sreg(sreg_o),
    .ext_rdata(ext_rdata), .ext_ready(ext_ready), .rdata(io_rdata), .ready(io_ready)
  );

  assign ext_we    = ext_req && io_wr;
  assign ext_addr  = EA_W'(IO_BASE) + EA_W'(io_addr);
  assign ext_wdata = wbyte;
  assign dext_o    = vals[NXD*XW-1:0];
  assign jext_o    = vals[NXD*XW +: XW];

  p_core_read_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && core_hit) |-> io_ready);

  p_ext_read_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && ext_req) |-> (io_ready == ext_ready) && (io_rdata == ext_rdata));

  p_ext_write_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_we |=> $stable(vals) && $stable(sp_o) && $stable(sreg_o));

  p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wdata_hi_seen && core_wr[SL_STAT]) |=> sreg_o == $past(io_wdata[7:0]));

endmodule

// File: tb/core_io_regfile_bench.sv
module core_io_regfile_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [15:0] io_wdata = '0;
  logic [7:0]  ext_rdata = '0;
  logic        ext_ready = 1'b0;

  logic [7:0]  rd_a, rd_b, ewd_a, ewd_b;
  logic        rdy_a, rdy_b, req_a, req_b, we_a, we_b;
  logic [15:0] ea_a, ea_b, sp_a, sp_b;
  logic [95:0] dx_a, dx_b;
  logic [23:0] jx_a, jx_b;
  logic [7:0]  st_a, st_b;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // A: restricted build; B: full build
  core_io_regfile #(.XD_EN(4'b0101), .SP_WIDE(1'b0)) u_core_io_regfile (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(rd_a), .io_ready(rdy_a), .ext_req(req_a),
    .ext_we(we_a), .ext_addr(ea_a), .ext_wdata(ewd_a), .ext_rdata(ext_rdata),
    .ext_ready(ext_ready), .dext_o(dx_a), .jext_o(jx_a), .sp_o(sp_a), .sreg_o(st_a));

  core_io_regfile #(.XD_EN(4'hF), .SP_WIDE(1'b1)) u_core_io_regfile_full (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(rd_b), .io_ready(rdy_b), .ext_req(req_b),
    .ext_we(we_b), .ext_addr(ea_b), .ext_wdata(ewd_b), .ext_rdata(ext_rdata),
    .ext_ready(ext_ready), .dext_o(dx_b), .jext_o(jx_b), .sp_o(sp_b), .sreg_o(st_b));

  logic [7:0] mdl_a [8];
  logic [7:0] mdl_b [8];

  function automatic logic [7:0] pat(input int p);
    return 8'((p * 37 + 11) & 255);
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [95:0] dext_of(input logic [7:0] m [8]);
    logic [95:0] v;
    for (int k = 0; k < 4; k++) v[24*k +: 24] = {m[k], 16'h0};
    return v;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) begin mdl_a[k] = 8'h0; mdl_b[k] = 8'h0; end
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1: reset state
    chk("R1 dext A", dx_a, 96'h0);
    chk("R1 dext B", dx_b, 96'h0);
    chk("R1 jext", {jx_a, jx_b}, 48'h0);
    chk("R1 sp/sreg", {sp_a, sp_b, st_a, st_b}, 48'h0);
    io_rd = 1'b1;
    for (int p = 56; p < 64; p++) begin
      io_addr = 6'(p); #1;
      chk("R1 read zero", {rd_a, rd_b}, 16'h0);
    end
    io_rd = 1'b0;
    tick();

    // Sweep every port: write then read back
    for (int p = 0; p < 64; p++) begin
      logic [7:0] b;
      b = pat(p);
      io_addr = 6'(p); io_wdata = {8'hC3, b}; io_wr = 1'b1; #1;
      if (p < 56) begin
        chk("R9 ext write req", {req_a, we_a, req_b, we_b}, 4'hF);
        chk("R9 ext addr", {ea_a, ea_b}, {16'(32 + p), 16'(32 + p)});
        chk("R8 ext wdata masked", {ewd_a, ewd_b}, {b, b});
      end else begin
        int k;
        k = p - 56;
        chk("R9 core no req", {req_a, req_b}, 2'b00);
        mdl_b[k] = b;
        if (!((k == 1) || (k == 3) || (k == 6))) mdl_a[k] = b;
      end
      tick();
      io_wr = 1'b0; io_rd = 1'b1; io_wdata = '0;
      if (p < 56) begin
        ext_rdata = 8'(p) ^ 8'h5A; ext_ready = 1'b0; #1;
        chk("R10 ext wait", {rdy_a, rdy_b, req_a, we_a}, 4'b0010);
        ext_ready = 1'b1; #1;
        chk("R10 ext read", {rdy_a, rdy_b, rd_a, rd_b},
            {2'b11, 8'(p) ^ 8'h5A, 8'(p) ^ 8'h5A});
        // R9: an external write leaves internal state unchanged
        chk("R9 ext write inert", {dx_a, jx_a, sp_a, st_a, 8'h0},
            {dext_of(mdl_a), mdl_a[4], 16'h0, mdl_a[6], mdl_a[5], mdl_a[7], 8'h0});
      end else begin
        int k;
        k = p - 56;
        ext_ready = 1'b0; ext_rdata = 8'hEE; #1;
        if (k < 4)       chk("R2/R3 ext read back", {rdy_a, rd_a, rdy_b, rd_b}, {1'b1, mdl_a[k], 1'b1, mdl_b[k]});
        else if (k == 4) chk("R4 jump read back",   {rdy_a, rd_a, rdy_b, rd_b}, {1'b1, mdl_a[k], 1'b1, mdl_b[k]});
        else if (k == 5) chk("R5 sp lo read back",  {rdy_a, rd_a, rdy_b, rd_b}, {1'b1, mdl_a[k], 1'b1, mdl_b[k]});
        else if (k == 6) chk("R6 sp hi read back",  {rdy_a, rd_a, rdy_b, rd_b}, {1'b1, mdl_a[k], 1'b1, mdl_b[k]});
        else             chk("R7 status read back", {rdy_a, rd_a, rdy_b, rd_b}, {1'b1, mdl_a[k], 1'b1, mdl_b[k]});
      end
      tick();
      io_rd = 1'b0; ext_ready = 1'b0;
    end

    // Exposed outputs after the sweep
    chk("R2 dext full", dx_b, dext_of(mdl_b));
    chk("R3 dext gated", dx_a, dext_of(mdl_a));
    chk("R3 gated slots zero", {dx_a[47:24], dx_a[95:72]}, 48'h0);
    chk("R4 jext", {jx_a, jx_b}, {pat(60), 16'h0, pat(60), 16'h0});
    chk("R6 sp hi wide/narrow", {sp_b[15:8], sp_a[15:8]}, {pat(62), 8'h00});
    chk("R7 sreg", {st_a, st_b}, {pat(63), pat(63)});
    chk("R8 upper bits dropped", {st_b, sp_b[7:0]}, {pat(63), pat(61)});

    // R5: low byte write keeps the high byte
    io_addr = 6'h3D; io_wdata = 16'hFF11; io_wr = 1'b1;
    tick();
    io_wr = 1'b0;
    chk("R5 low write only", {sp_a, sp_b}, {8'h00, 8'h11, pat(62), 8'h11});

    // R6: narrow build ignores a second high-byte write too
    io_addr = 6'h3E; io_wdata = 16'h0077; io_wr = 1'b1;
    tick();
    io_wr = 1'b0;
    chk("R6 narrow ignore", {sp_a, sp_b}, {16'h0011, 16'h7711});

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule